// File: doc/BRIEF.md
# Wishbone debug command executor

This block sits between a command queue and a response queue in a host-driven debug path. It takes one 36-bit command record at a time and turns it into a single transfer on a 32-bit pipelined Wishbone B4 master port. For every command that calls for an answer, it writes one 36-bit response record. Each record keeps the opcode in bits [35:32] and the payload in bits [31:0]. The block holds the current bus address and an auto-increment flag. Set-address commands load these, and reads and writes use them. An out-of-band bus-reset input overrides any transfer in progress, including one that is stalled.

The control is one state machine with four states:
- `ST_IDLE`: waits for a command and decodes it.
- `ST_REQ`: drives the strobe until the slave accepts it.
- `ST_WAIT`: keeps the cycle open until ack or err arrives.
- `ST_RST`: holds the bus idle while bus reset is asserted.

Its transitions are:
- `ST_IDLE` to `ST_REQ` when a read or write is popped.
- `ST_REQ` to `ST_WAIT` when stall is low.
- `ST_REQ` or `ST_WAIT` to `ST_IDLE` when ack or err arrives.
- Any state to `ST_RST` while bus reset is high.
- `ST_RST` to `ST_IDLE` when bus reset is low and the response queue has room.

Top module: `dbg_cmd_exec`

## Requirements
- R1: After reset, cyc, stb, cmd_pop and rsp_push are low, the address register is 0 and auto-increment is off.
- R2: Opcode 4'b0011 loads the address from the command's low 32 bits and clears auto-increment. It pushes response {4'b0011, 32'h0} in the same cycle that it pops the command.
- R3: Opcode 4'b0111 loads the address and sets auto-increment. It also pushes {4'b0011, 32'h0}.
- R4: Opcode 4'b0001 runs one read (we=0) at the current address. When ack arrives, it pushes {4'b0001, read data} in that same cycle.
- R5: Opcode 4'b0010 runs one write (we=1) of the command's low 32 bits at the current address. On ack it pushes {4'b0010, 32'h0}.
- R6: Strobe stays high, with cyc, for as long as stall is high. It drops the cycle after it is accepted, and cyc stays high until ack or err.
- R7: With auto-increment on, the address grows by 1 after each acked read or write. With auto-increment off, it is unchanged.
- R8: When err ends a transfer, the block pushes {4'b0100, 32'h0} and the address does not advance.
- R9: While bus_reset_req is high, cyc and stb are low in that same cycle, even during a stall, and nothing is pushed. After it falls, one {4'b0101, 32'h0} is pushed, the address is cleared and auto-increment is off.
- R10: Opcode 4'b1111 arriving as a command pushes {4'b0101, 32'h0} and clears the address and auto-increment.
- R11: No command is popped while rsp_full is high.
- R12: Any other opcode is popped and discarded, with no response and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset_req | input | 1 | Out-of-band bus reset request |
| cmd_valid | input | 1 | Command queue not empty |
| cmd_data | input | 36 | Command record at queue head |
| cmd_pop | output | 1 | Remove the head command |
| rsp_full | input | 1 | Response queue full |
| rsp_push | output | 1 | Write a response record |
| rsp_data | output | 36 | Response record |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 32 | Bus address |
| wb_dat_w | output | 32 | Write data |
| wb_ack | input | 1 | Slave acknowledge |
| wb_err | input | 1 | Slave error |
| wb_stall | input | 1 | Slave stall |
| wb_dat_r | input | 32 | Read data |

## Verification
The hardest situation to reach is a bus reset that lands while a strobe is being held against a stall that never clears. From the ports this looks like a hung slave. The bench's slave model is loaded with a very long stall count, and a read is queued behind it. The bench waits until cyc is seen high and then raises the reset request at a falling edge. It checks that cyc and stb fall in that same cycle and that no response leaks out while the request is held. It then checks that exactly one reset acknowledge follows, and that a read issued next goes to address 0.

// File: rtl/dbg_exec_pkg.sv
package dbg_exec_pkg;
    localparam int OPW = 4;

    localparam logic [OPW-1:0] CMD_READ   = 4'b0001;
    localparam logic [OPW-1:0] CMD_WRITE  = 4'b0010;
    localparam logic [OPW-1:0] CMD_SETA   = 4'b0011;
    localparam logic [OPW-1:0] CMD_SETAI  = 4'b0111;
    localparam logic [OPW-1:0] CMD_BRESET = 4'b1111;

    localparam logic [OPW-1:0] RSP_READ   = 4'b0001;
    localparam logic [OPW-1:0] RSP_WRACK  = 4'b0010;
    localparam logic [OPW-1:0] RSP_ADRACK = 4'b0011;
    localparam logic [OPW-1:0] RSP_BUSERR = 4'b0100;
    localparam logic [OPW-1:0] RSP_RSTACK = 4'b0101;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_RST
    } exec_state_t;
endpackage

// File: rtl/dbg_addr_reg.sv
module dbg_addr_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_inc,
    input  logic [AW-1:0] load_val,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          inc_en
);
    logic [AW-1:0] addr_q;
    logic          inc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr_q <= '0;
            inc_q  <= 1'b0;
        end else if (load) begin
            addr_q <= load_val;
            inc_q  <= load_inc;
        end else if (step && inc_q) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr   = addr_q;
    assign inc_en = inc_q;

    // R7: step with auto-increment on advances by exactly one
    a_r7_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc_q && !load && !clear) |=> (addr_q == $past(addr_q) + 1'b1));

    // R7: step with auto-increment off leaves the address alone
    a_r7_no_step_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inc_q && !load && !clear) |=> $stable(addr_q));
endmodule

// File: rtl/dbg_exec_fsm.sv
module dbg_exec_fsm
    import dbg_exec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_reset_req,
    input  logic           cmd_valid,
    input  logic [OPW-1:0] cmd_op,
    input  logic [DW-1:0]  cmd_arg,
    output logic           cmd_pop,
    input  logic           rsp_full,
    output logic           rsp_push,
    output logic [OPW-1:0] rsp_op,
    output logic           addr_load,
    output logic           addr_load_inc,
    output logic           addr_clear,
    output logic           addr_step,
    output logic           wb_cyc,
    output logic           wb_stb,
    output logic           wb_we,
    output logic [DW-1:0]  wb_dat_w,
    input  logic           wb_ack,
    input  logic           wb_err,
    input  logic           wb_stall
);
    exec_state_t   state_q, state_d;
    logic          we_q;
    logic [DW-1:0] wdat_q;
    logic          take;
    logic          is_xfer;
    logic          done;

    assign take    = cmd_valid && !rsp_full && !bus_reset_req;
    assign is_xfer = (cmd_op == CMD_READ) || (cmd_op == CMD_WRITE);
    assign done    = wb_ack || wb_err;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            wdat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_pop && is_xfer) begin
                we_q   <= (cmd_op == CMD_WRITE);
                wdat_q <= cmd_arg;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (bus_reset_req) begin
            state_d = ST_RST;
        end else begin
            unique case (state_q)
                ST_IDLE: if (take && is_xfer) state_d = ST_REQ;
                ST_REQ:  if (done) state_d = ST_IDLE;
                         else if (!wb_stall) state_d = ST_WAIT;
                ST_WAIT: if (done) state_d = ST_IDLE;
                ST_RST:  if (!rsp_full) state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_pop       = 1'b0;
        rsp_push      = 1'b0;
        rsp_op        = RSP_ADRACK;
        addr_load     = 1'b0;
        addr_load_inc = 1'b0;
        addr_clear    = 1'b0;
        addr_step     = 1'b0;
        wb_cyc        = 1'b0;
        wb_stb        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    cmd_pop = 1'b1;
                    case (cmd_op)
                        CMD_SETA, CMD_SETAI: begin
                            addr_load     = 1'b1;
                            addr_load_inc = (cmd_op == CMD_SETAI);
                            rsp_push      = 1'b1;
                            rsp_op        = RSP_ADRACK;
                        end
                        CMD_BRESET: begin
                            addr_clear = 1'b1;
                            rsp_push   = 1'b1;
                            rsp_op     = RSP_RSTACK;
                        end
                        default: ;
                    endcase
                end
            end
            ST_REQ, ST_WAIT: begin
                wb_cyc = 1'b1;
                wb_stb = (state_q == ST_REQ);
                if (done) begin
                    rsp_push  = 1'b1;
                    rsp_op    = wb_err ? RSP_BUSERR : (we_q ? RSP_WRACK : RSP_READ);
                    addr_step = !wb_err;
                end
            end
            ST_RST: begin
                if (!rsp_full) begin
                    rsp_push   = 1'b1;
                    rsp_op     = RSP_RSTACK;
                    addr_clear = 1'b1;
                end
            end
        endcase
        if (bus_reset_req) begin
            wb_cyc     = 1'b0;
            wb_stb     = 1'b0;
            rsp_push   = 1'b0;
            addr_step  = 1'b0;
            addr_clear = 1'b0;
        end
    end

    assign wb_we    = we_q;
    assign wb_dat_w = wdat_q;

    a_r6_stb_within_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_cyc);

    a_r6_stb_held_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_stall && !done && !bus_reset_req) |=> (wb_stb || bus_reset_req));

    a_r6_stb_drops_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && !wb_stall && !done) |=> !wb_stb);

    a_r9_reset_drops_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_reset_req) |=> (!wb_cyc && !wb_stb));

    a_r11_no_pop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> !cmd_pop);
endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
    import dbg_exec_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int RW = OPW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset_req,
    input  logic          cmd_valid,
    input  logic [RW-1:0] cmd_data,
    output logic          cmd_pop,
    input  logic          rsp_full,
    output logic          rsp_push,
    output logic [RW-1:0] rsp_data,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic          wb_we,
    output logic [AW-1:0] wb_adr,
    output logic [DW-1:0] wb_dat_w,
    input  logic          wb_ack,
    input  logic          wb_err,
    input  logic          wb_stall,
    input  logic [DW-1:0] wb_dat_r
);
    logic [OPW-1:0] rsp_op;
    logic           addr_load, addr_load_inc, addr_clear, addr_step;
    logic           inc_en;

    dbg_exec_fsm #(.DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_reset_req (bus_reset_req),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_data[RW-1:DW]),
        .cmd_arg       (cmd_data[DW-1:0]),
        .cmd_pop       (cmd_pop),
        .rsp_full      (rsp_full),
        .rsp_push      (rsp_push),
        .rsp_op        (rsp_op),
        .addr_load     (addr_load),
        .addr_load_inc (addr_load_inc),
        .addr_clear    (addr_clear),
        .addr_step     (addr_step),
        .wb_cyc        (wb_cyc),
        .wb_stb        (wb_stb),
        .wb_we         (wb_we),
        .wb_dat_w      (wb_dat_w),
        .wb_ack        (wb_ack),
        .wb_err        (wb_err),
        .wb_stall      (wb_stall)
    );

    dbg_addr_reg #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_inc (addr_load_inc),
        .load_val (cmd_data[AW-1:0]),
        .clear    (addr_clear),
        .step     (addr_step),
        .addr     (wb_adr),
        .inc_en   (inc_en)
    );

    assign rsp_data = {rsp_op, (rsp_op == RSP_READ) ? wb_dat_r : {DW{1'b0}}};

    // R8: an error response never comes with the address moving on
    a_r8_err_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_push && rsp_op == RSP_BUSERR) |=> $stable(wb_adr));

    // R3: auto-increment load is visible on the next cycle
    a_r3_inc_mode_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pop && cmd_data[RW-1:DW] == CMD_SETAI) |=> inc_en);
endmodule

// File: tb/dbg_cmd_exec_tb.sv
`timescale 1ns/1ps
module dbg_cmd_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset_req = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [35:0] cmd_data = '0;
    logic        cmd_pop;
    logic        rsp_full = 1'b0;
    logic        rsp_push;
    logic [35:0] rsp_data;
    logic        wb_cyc, wb_stb, wb_we;
    logic [31:0] wb_adr, wb_dat_w;
    logic        wb_ack = 1'b0, wb_err = 1'b0, wb_stall = 1'b0;
    logic [31:0] wb_dat_r = '0;

    always #2.5 clk = ~clk;

    dbg_cmd_exec u_dut (
        .clk(clk), .rst_n(rst_n), .bus_reset_req(bus_reset_req),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
        .rsp_full(rsp_full), .rsp_push(rsp_push), .rsp_data(rsp_data),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_w(wb_dat_w), .wb_ack(wb_ack), .wb_err(wb_err),
        .wb_stall(wb_stall), .wb_dat_r(wb_dat_r)
    );

    int errs = 0, checks = 0;
    logic [35:0] cmd_q[$];
    logic [35:0] exp_rsp[$];
    string       exp_tag[$];
    logic [64:0] exp_bus[$];
    string       bus_tag[$];
    int  stall_left = 0, wait_cfg = 0, wait_left = 0;
    bit  err_cfg = 0, pending = 0, pop_flag = 0;
    logic [31:0] acc_addr = '0;
    int  rsp_count = 0, pop_count = 0;
    logic [31:0] maddr = '0;
    bit  minc = 0;

    function automatic logic [31:0] rd_val(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // slave model and per-clock comparison against the reference queues
    initial forever begin
        @(negedge clk);
        if (pop_flag) begin void'(cmd_q.pop_front()); pop_flag = 0; end
        wb_ack = 0; wb_err = 0;
        if (pending) begin
            if (wait_left == 0) begin
                if (err_cfg) wb_err = 1; else wb_ack = 1;
                pending = 0;
            end else wait_left--;
        end
        wb_dat_r  = wb_ack ? rd_val(acc_addr) : 32'h0;
        wb_stall  = (stall_left > 0);
        cmd_valid = (cmd_q.size() > 0);
        cmd_data  = cmd_valid ? cmd_q[0] : 36'h0;
        #1;
        if (rst_n) begin
            if (wb_stb && !wb_cyc) chk(0, "R6", "stb without cyc", 0, 1);
            if (wb_cyc && wb_stb) begin
                if (wb_stall) stall_left--;
                else if (exp_bus.size() == 0) chk(0, "R12", "unexpected bus transfer", {31'h0, wb_we, wb_adr}, 0);
                else begin
                    logic [64:0] e;
                    string t;
                    e = exp_bus.pop_front(); t = bus_tag.pop_front();
                    chk(wb_we == e[64] && wb_adr == e[63:32] && (!e[64] || wb_dat_w == e[31:0]),
                        t, "bus transfer {we,adr,dat}", {wb_we, wb_adr, wb_dat_w}, e[63:0] | {e[64], 63'h0});
                    pending = 1; wait_left = wait_cfg; acc_addr = wb_adr;
                end
            end
            if (cmd_pop) begin pop_flag = 1; pop_count++; end
            if (rsp_push) begin
                rsp_count++;
                if (exp_rsp.size() == 0) chk(0, "R12", "unexpected response", {28'h0, rsp_data}, 0);
                else begin
                    logic [35:0] e;
                    string t;
                    e = exp_rsp.pop_front(); t = exp_tag.pop_front();
                    chk(rsp_data == e, t, "response record", {28'h0, rsp_data}, {28'h0, e});
                end
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (cmd_q.size() != 0 || exp_rsp.size() != 0 || pending);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_seta(logic [31:0] a, bit inc, string t);
        cmd_q.push_back({(inc ? 4'b0111 : 4'b0011), a});
        exp_rsp.push_back({4'b0011, 32'h0}); exp_tag.push_back(t);
        maddr = a; minc = inc;
        wait_idle();
    endtask

    task automatic do_xfer(bit we, logic [31:0] d, int st, int wt, bit er, string t);
        stall_left = st; wait_cfg = wt; err_cfg = er;
        exp_bus.push_back({we, maddr, d}); bus_tag.push_back(t);
        if (er) exp_rsp.push_back({4'b0100, 32'h0});
        else if (we) exp_rsp.push_back({4'b0010, 32'h0});
        else exp_rsp.push_back({4'b0001, rd_val(maddr)});
        exp_tag.push_back(t);
        if (!er && minc) maddr++;
        cmd_q.push_back({(we ? 4'b0010 : 4'b0001), d});
        wait_idle();
        err_cfg = 0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #1;
        chk(!wb_cyc && !wb_stb && !cmd_pop && !rsp_push, "R1", "outputs during reset",
            {wb_cyc, wb_stb, cmd_pop, rsp_push}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #1;
        chk(!wb_cyc && !wb_stb && !rsp_push, "R1", "outputs after reset", {wb_cyc, wb_stb, rsp_push}, 0);
        do_xfer(0, 0, 0, 0, 0, "R1");                       // read at address 0
        do_xfer(0, 0, 0, 0, 0, "R1");                       // auto-increment off at reset
        do_seta(32'h0000_0100, 0, "R2");
        do_xfer(1, 32'hDEAD_BEEF, 0, 0, 0, "R5");
        do_xfer(0, 0, 2, 1, 0, "R4");                       // stalled read
        do_xfer(1, 32'h1234_5678, 0, 0, 0, "R7");           // still 0x100: no increment
        do_seta(32'h0000_0200, 1, "R3");
        do_xfer(0, 0, 0, 0, 0, "R7");
        do_xfer(0, 0, 3, 2, 0, "R7");
        do_xfer(1, 32'hCAFE_0001, 4, 0, 0, "R6");
        do_xfer(0, 0, 1, 1, 1, "R8");                       // error: no increment
        do_xfer(0, 0, 0, 0, 0, "R8");
        do_xfer(1, 32'h0BAD_F00D, 0, 3, 1, "R8");
        do_xfer(1, 32'h0000_0042, 0, 0, 0, "R8");
        do_seta(32'hFFFF_FFFF, 1, "R3");
        do_xfer(0, 0, 0, 0, 0, "R7");                       // wraps to 0
        do_xfer(0, 0, 0, 0, 0, "R7");

        // R12: unknown opcode is dropped
        begin
            int rc;
            rc = rsp_count;
            cmd_q.push_back({4'b0101, 32'h1111_2222});
            wait_idle();
            chk(rsp_count == rc, "R12", "response count after unknown opcode", rsp_count, rc);
            chk(cmd_q.size() == 0, "R12", "unknown opcode popped", cmd_q.size(), 0);
        end
        do_xfer(0, 0, 0, 0, 0, "R12");                      // address untouched

        // R11: full response queue blocks popping
        begin
            int pc, rc;
            @(negedge clk); rsp_full = 1;
            pc = pop_count; rc = rsp_count;
            cmd_q.push_back({4'b0011, 32'h0000_0500});
            repeat (6) @(negedge clk);
            chk(pop_count == pc, "R11", "pops while full", pop_count, pc);
            chk(rsp_count == rc, "R11", "pushes while full", rsp_count, rc);
            exp_rsp.push_back({4'b0011, 32'h0}); exp_tag.push_back("R11");
            maddr = 32'h500; minc = 0;
            rsp_full = 0;
            wait_idle();
        end
        do_xfer(0, 0, 0, 0, 0, "R11");

        // R9: bus reset during an endless stall
        begin
            int rc;
            stall_left = 100000; wait_cfg = 0;
            exp_bus.push_back({1'b0, maddr, 32'h0}); bus_tag.push_back("R9");
            cmd_q.push_back({4'b0001, 32'h0});
            do begin @(negedge clk); #1; end while (!wb_cyc);
            @(negedge clk);
            bus_reset_req = 1;
            #2;
            chk(!wb_cyc && !wb_stb, "R9", "cyc/stb during bus reset", {wb_cyc, wb_stb}, 0);
            void'(exp_bus.pop_front()); void'(bus_tag.pop_front());
            rc = rsp_count;
            repeat (3) begin
                @(negedge clk); #1;
                chk(!wb_cyc && !wb_stb, "R9", "bus idle while reset held", {wb_cyc, wb_stb}, 0);
            end
            chk(rsp_count == rc, "R9", "no push while reset held", rsp_count, rc);
            @(negedge clk);
            stall_left = 0;
            exp_rsp.push_back({4'b0101, 32'h0}); exp_tag.push_back("R9");
            maddr = 0; minc = 0;
            bus_reset_req = 0;
            wait_idle();
            chk(rsp_count == rc + 1, "R9", "single reset acknowledge", rsp_count, rc + 1);
        end
        do_xfer(0, 0, 0, 0, 0, "R9");                       // address cleared
        do_xfer(0, 0, 0, 0, 0, "R9");                       // auto-increment cleared

        // R10: bus reset as a queued command
        do_seta(32'h0000_0777, 1, "R3");
        cmd_q.push_back({4'b1111, 32'h0});
        exp_rsp.push_back({4'b0101, 32'h0}); exp_tag.push_back("R10");
        maddr = 0; minc = 0;
        wait_idle();
        do_xfer(0, 0, 0, 0, 0, "R10");
        do_xfer(1, 32'h0000_00AA, 0, 0, 0, "R10");

        chk(exp_rsp.size() == 0 && exp_bus.size() == 0, "R4", "outstanding expectations",
            exp_rsp.size() + exp_bus.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule